// File: doc/BRIEF.md
# CEC Bit-Timing Receiver

This block turns the single-wire consumer-electronics control line into decoded protocol events. The line is resynchronised into the core clock domain. Its level is then looked at only on a slow time-base strobe, nominally 32768 Hz, so one tick is about 30.5 us. The block measures every low phase, high phase and bit period in ticks. It compares each figure against windows held in loadable registers. From that it reports start bits, data bits and timing errors as single-clock strobes.

Decoded bits are gathered into 10-bit blocks: eight data bits, then the end-of-message flag, then the acknowledge bit. Each complete block is presented on one strobe. Driving the line, acknowledging and arbitration belong to other logic. This block only listens.

Any timing violation sends the block back to looking for a start bit. The falling edge that revealed the violation is kept as the possible beginning of a new start bit.

Top module: `cec_bit_receiver`

## Requirements
- R1: While `rst` is high and on the first clock after it, `start_det`, `bit_vld`, `err_vld` and `blk_vld` are 0. Reset loads the thresholds, in ticks: 0 start-low-min 115, 1 start-low-max 128, 2 start-high-min 20, 3 start-high-max 33, 4 start-total-min 141, 5 start-total-max 154, 6 one-low-min 13, 7 one-low-max 26, 8 zero-low-min 43, 9 zero-low-max 56, 10 period-min 67, 11 high-max 92, 12 low-error 111.
- R2: The line passes through a two-flop synchronizer and is examined only in cycles where `tick` is 1. A level held for N ticks measures N. Every output strobe lasts one clock and follows a tick cycle.
- R3: A start bit is accepted when its low time is in [115,128], its high time in [20,33] and its total period in [141,154]. `start_det` pulses on the falling edge that ends the start bit.
- R4: A start-bit violation raises `err_vld` with `err_kind`=0. A low that is too short or too long is flagged at the rising edge, or at tick 129 if the line is still low. A bad high time or total period is flagged at the ending fall. A high lasting more than 33 ticks is flagged while the line is still high.
- R5: A data bit whose low time is in [13,26] is a 1, and one in [43,56] is a 0. `bit_vld` pulses with `bit_val` at the rising edge.
- R6: A data low time outside both windows gives `err_kind`=1 at the rising edge. A data low that has not ended by tick 112 gives `err_kind`=1 at that tick.
- R7: A data bit period shorter than 67 ticks gives `err_kind`=2 at the falling edge that closes it.
- R8: A high phase longer than 92 ticks after a data bit gives `err_kind`=3, unless the last completed block had its end-of-message flag set.
- R9: Bits are collected in arrival order: eight data bits MSB first, then EOM, then ACK. `blk_vld` pulses one clock after the tenth `bit_vld`, with `blk_data`, `blk_eom` and `blk_ack`.
- R10: After a block with EOM=1, a long idle high gives no error. The next falling edge is taken as the start of a start bit.
- R11: A `cfg_wr` pulse writes `cfg_data` into the threshold numbered `cfg_idx` (0 to 12, as listed in R1). The new value applies from the next tick.
- R12: After any error the block hunts for a start bit. If the error was detected at a falling edge, that edge begins the candidate start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle time-base strobe (about 30.5 us) |
| cec_line | input | 1 | Asynchronous bus line level |
| cfg_wr | input | 1 | Threshold write strobe |
| cfg_idx | input | 4 | Threshold number |
| cfg_data | input | 10 | Threshold value in ticks |
| start_det | output | 1 | Valid start bit seen |
| bit_vld | output | 1 | Data bit decoded |
| bit_val | output | 1 | Value of the decoded bit |
| err_vld | output | 1 | Timing error |
| err_kind | output | 2 | 0 start, 1 data low, 2 short period, 3 long high |
| blk_vld | output | 1 | 10-bit block complete |
| blk_data | output | 8 | Block data byte |
| blk_eom | output | 1 | Block end-of-message flag |
| blk_ack | output | 1 | Block acknowledge bit |

## Verification
The bench targets every window edge: low times of 12, 13, 26, 27, 56 and 57 ticks, periods of 66 and 67, and high phases of 92 and 94. A design off by one in counting from the falling edge would move each of these results by one tick. It also sends a low that never ends, to show the logic-error limit fires while the line is still low. Whole frames are sent with the end-of-message flag set and clear. A receiver that kept no memory of the flag would either report a false error on a normal idle bus or miss a frame that was cut short. A rejected start bit followed at once by a good one checks that the block does not drop the falling edge it used to reject the first. A threshold rewrite checks that decoding follows the registers and not constants.

// File: rtl/cecrx_pkg.sv
package cecrx_pkg;

    localparam int NTHR  = 13;
    localparam int IDX_W = 4;

    // threshold numbering
    localparam int T_ST_LOW_MIN  = 0;
    localparam int T_ST_LOW_MAX  = 1;
    localparam int T_ST_HIGH_MIN = 2;
    localparam int T_ST_HIGH_MAX = 3;
    localparam int T_ST_TOT_MIN  = 4;
    localparam int T_ST_TOT_MAX  = 5;
    localparam int T_ONE_MIN     = 6;
    localparam int T_ONE_MAX     = 7;
    localparam int T_ZERO_MIN    = 8;
    localparam int T_ZERO_MAX    = 9;
    localparam int T_PER_MIN     = 10;
    localparam int T_HIGH_MAX    = 11;
    localparam int T_LOW_ERR     = 12;

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } rx_state_e;

    typedef enum logic [1:0] {
        ERR_START  = 2'd0,
        ERR_LOW    = 2'd1,
        ERR_PERIOD = 2'd2,
        ERR_HIGH   = 2'd3
    } err_kind_e;

    typedef struct packed {
        logic      start;
        logic      bit_vld;
        logic      bit_val;
        logic      err;
        err_kind_e kind;
    } rx_event_t;

    // reset values in ticks of a 32768 Hz time base
    function automatic int unsigned thr_default(input int unsigned idx);
        case (idx)
            T_ST_LOW_MIN:  return 115;
            T_ST_LOW_MAX:  return 128;
            T_ST_HIGH_MIN: return 20;
            T_ST_HIGH_MAX: return 33;
            T_ST_TOT_MIN:  return 141;
            T_ST_TOT_MAX:  return 154;
            T_ONE_MIN:     return 13;
            T_ONE_MAX:     return 26;
            T_ZERO_MIN:    return 43;
            T_ZERO_MAX:    return 56;
            T_PER_MIN:     return 67;
            T_HIGH_MAX:    return 92;
            T_LOW_ERR:     return 111;
            default:       return 0;
        endcase
    endfunction

endpackage

// File: rtl/cecrx_line_in.sv
module cecrx_line_in #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic line,
    output logic fall,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              prev;
    logic              cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '1;
            prev  <= 1'b1;
        end else begin
            chain <= {chain[STAGES-2:0], line};
            if (tick) prev <= cur;
        end
    end

    assign cur  = chain[STAGES-1];
    assign fall = tick & prev & ~cur;
    assign rise = tick & ~prev & cur;
endmodule

// File: rtl/cecrx_thr_regs.sv
module cecrx_thr_regs
    import cecrx_pkg::*;
#(
    parameter int TW = 10
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cfg_wr,
    input  logic [IDX_W-1:0]          cfg_idx,
    input  logic [TW-1:0]             cfg_data,
    output logic [NTHR-1:0][TW-1:0]   thr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NTHR; i++) thr[i] <= TW'(thr_default(i));
        end else if (cfg_wr) begin
            for (int i = 0; i < NTHR; i++)
                if (cfg_idx == IDX_W'(i)) thr[i] <= cfg_data;
        end
    end
endmodule

// File: rtl/cecrx_bit_fsm.sv
module cecrx_bit_fsm
    import cecrx_pkg::*;
#(
    parameter int TW = 10
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    tick,
    input  logic                    fall,
    input  logic                    rise,
    input  logic                    frame_end,
    input  logic [NTHR-1:0][TW-1:0] thr,
    output rx_event_t               ev
);
    localparam logic [TW-1:0] CNT_MAX = '1;

    rx_state_e     state, st_n;
    logic [TW-1:0] cnt, low_len, low_n;
    logic          is_start, start_n;
    logic [TW-1:0] el, hi_el;
    rx_event_t     ev_n;

    function automatic logic win(input logic [TW-1:0] v, lo, hi);
        return (v >= lo) && (v <= hi);
    endfunction

    // ticks since the last falling edge, saturating
    assign el    = (cnt == CNT_MAX) ? cnt : cnt + TW'(1);
    assign hi_el = el - low_len;

    always_comb begin
        st_n    = state;
        low_n   = low_len;
        start_n = is_start;
        ev_n    = '0;
        if (tick) begin
            unique case (state)
                ST_HUNT: begin
                    if (fall) begin
                        st_n    = ST_LOW;
                        start_n = 1'b1;
                    end
                end
                ST_LOW: begin
                    if (rise) begin
                        low_n = el;
                        if (is_start) begin
                            if (win(el, thr[T_ST_LOW_MIN], thr[T_ST_LOW_MAX])) st_n = ST_HIGH;
                            else begin
                                ev_n.err  = 1'b1;
                                ev_n.kind = ERR_START;
                                st_n      = ST_HUNT;
                            end
                        end else if (win(el, thr[T_ONE_MIN], thr[T_ONE_MAX])) begin
                            ev_n.bit_vld = 1'b1;
                            ev_n.bit_val = 1'b1;
                            st_n         = ST_HIGH;
                        end else if (win(el, thr[T_ZERO_MIN], thr[T_ZERO_MAX])) begin
                            ev_n.bit_vld = 1'b1;
                            ev_n.bit_val = 1'b0;
                            st_n         = ST_HIGH;
                        end else begin
                            ev_n.err  = 1'b1;
                            ev_n.kind = ERR_LOW;
                            st_n      = ST_HUNT;
                        end
                    end else if (is_start && el > thr[T_ST_LOW_MAX]) begin
                        ev_n.err  = 1'b1;
                        ev_n.kind = ERR_START;
                        st_n      = ST_HUNT;
                    end else if (!is_start && el > thr[T_LOW_ERR]) begin
                        ev_n.err  = 1'b1;
                        ev_n.kind = ERR_LOW;
                        st_n      = ST_HUNT;
                    end
                end
                ST_HIGH: begin
                    if (fall) begin
                        st_n = ST_LOW;
                        if (is_start) begin
                            if (win(hi_el, thr[T_ST_HIGH_MIN], thr[T_ST_HIGH_MAX]) &&
                                win(el, thr[T_ST_TOT_MIN], thr[T_ST_TOT_MAX])) begin
                                ev_n.start = 1'b1;
                                start_n    = 1'b0;
                            end else begin
                                ev_n.err  = 1'b1;
                                ev_n.kind = ERR_START;
                                start_n   = 1'b1;
                            end
                        end else if (el >= thr[T_PER_MIN]) begin
                            start_n = frame_end;
                        end else begin
                            ev_n.err  = 1'b1;
                            ev_n.kind = ERR_PERIOD;
                            start_n   = 1'b1;
                        end
                    end else if (is_start && hi_el > thr[T_ST_HIGH_MAX]) begin
                        ev_n.err  = 1'b1;
                        ev_n.kind = ERR_START;
                        st_n      = ST_HUNT;
                    end else if (!is_start && hi_el > thr[T_HIGH_MAX]) begin
                        ev_n.err  = !frame_end;
                        ev_n.kind = ERR_HIGH;
                        st_n      = ST_HUNT;
                    end
                end
                default: st_n = ST_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_HUNT;
            cnt      <= '0;
            low_len  <= '0;
            is_start <= 1'b1;
            ev       <= '0;
        end else begin
            ev       <= ev_n;
            state    <= st_n;
            low_len  <= low_n;
            is_start <= start_n;
            if (tick) cnt <= fall ? '0 : el;
        end
    end
endmodule

// File: rtl/cecrx_block_asm.sv
module cecrx_block_asm
    import cecrx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  rx_event_t         ev,
    output logic              blk_vld,
    output logic [DATA_W-1:0] blk_data,
    output logic              blk_eom,
    output logic              blk_ack,
    output logic              frame_end
);
    localparam int BLK_W = DATA_W + 2;
    localparam int CW    = $clog2(BLK_W);

    logic [BLK_W-2:0] sh;
    logic [CW-1:0]    n;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh        <= '0;
            n         <= '0;
            blk_vld   <= 1'b0;
            blk_data  <= '0;
            blk_eom   <= 1'b0;
            blk_ack   <= 1'b0;
            frame_end <= 1'b0;
        end else begin
            blk_vld <= 1'b0;
            if (ev.start || ev.err) begin
                n         <= '0;
                frame_end <= 1'b0;
            end else if (ev.bit_vld) begin
                sh <= {sh[BLK_W-3:0], ev.bit_val};
                if (n == CW'(BLK_W - 1)) begin
                    blk_vld   <= 1'b1;
                    blk_data  <= sh[BLK_W-2:1];
                    blk_eom   <= sh[0];
                    blk_ack   <= ev.bit_val;
                    frame_end <= sh[0];
                    n         <= '0;
                end else begin
                    n         <= n + CW'(1);
                    frame_end <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/cec_bit_receiver.sv
module cec_bit_receiver
    import cecrx_pkg::*;
#(
    parameter int TW          = 10,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              cec_line,
    input  logic              cfg_wr,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [TW-1:0]     cfg_data,
    output logic              start_det,
    output logic              bit_vld,
    output logic              bit_val,
    output logic              err_vld,
    output logic [1:0]        err_kind,
    output logic              blk_vld,
    output logic [DATA_W-1:0] blk_data,
    output logic              blk_eom,
    output logic              blk_ack
);
    logic                    fall, rise, frame_end;
    logic [NTHR-1:0][TW-1:0] thr;
    rx_event_t               ev;

    cecrx_line_in #(.STAGES(SYNC_STAGES)) u_line (
        .clk(clk), .rst(rst), .tick(tick), .line(cec_line),
        .fall(fall), .rise(rise)
    );

    cecrx_thr_regs #(.TW(TW)) u_thr (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx),
        .cfg_data(cfg_data), .thr(thr)
    );

    cecrx_bit_fsm #(.TW(TW)) u_fsm (
        .clk(clk), .rst(rst), .tick(tick), .fall(fall), .rise(rise),
        .frame_end(frame_end), .thr(thr), .ev(ev)
    );

    cecrx_block_asm #(.DATA_W(DATA_W)) u_asm (
        .clk(clk), .rst(rst), .ev(ev), .blk_vld(blk_vld), .blk_data(blk_data),
        .blk_eom(blk_eom), .blk_ack(blk_ack), .frame_end(frame_end)
    );

    assign start_det = ev.start;
    assign bit_vld   = ev.bit_vld;
    assign bit_val   = ev.bit_val;
    assign err_vld   = ev.err;
    assign err_kind  = ev.kind;
endmodule

// File: rtl/cecrx_checker.sv
module cecrx_checker (
    input logic clk,
    input logic rst,
    input logic tick,
    input logic start_det,
    input logic bit_vld,
    input logic err_vld,
    input logic blk_vld
);
    // R1: first clock after reset carries no event
    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> !(start_det || bit_vld || err_vld || blk_vld));

    // R2: every event follows a tick cycle
    assert_event_after_tick_R2: assert property (@(posedge clk) disable iff (rst)
        (start_det || bit_vld || err_vld) |-> $past(tick));

    // R3: start detection and a data bit never coincide
    assert_start_vs_bit_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({start_det, bit_vld}));

    // R6: a rejected low never also yields a bit
    assert_err_vs_bit_R6: assert property (@(posedge clk) disable iff (rst)
        err_vld |-> !bit_vld);

    // R9: a block is presented right after a bit
    assert_block_after_bit_R9: assert property (@(posedge clk) disable iff (rst)
        blk_vld |-> $past(bit_vld));
endmodule

bind cec_bit_receiver cecrx_checker u_chk (
    .clk(clk), .rst(rst), .tick(tick), .start_det(start_det),
    .bit_vld(bit_vld), .err_vld(err_vld), .blk_vld(blk_vld)
);

// File: tb/cec_bit_receiver_tb.sv
`timescale 1ns/1ps
module cec_bit_receiver_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick;
    logic       cec_line = 1'b1;
    logic       cfg_wr = 1'b0;
    logic [3:0] cfg_idx = '0;
    logic [9:0] cfg_data = '0;
    logic       start_det, bit_vld, bit_val, err_vld, blk_vld, blk_eom, blk_ack;
    logic [1:0] err_kind;
    logic [7:0] blk_data;

    logic [1:0] ph = 2'd0;
    int checks = 0, failures = 0;
    int nstart, nbits, nerr, nblk, last_bit, last_kind;
    logic [7:0] last_data;
    logic       last_eom, last_ack;
    bit         done = 1'b0;

    always #5 clk = ~clk;
    always @(negedge clk) ph <= ph + 2'd1;
    assign tick = (ph == 2'd0);

    cec_bit_receiver dut_i (
        .clk(clk), .rst(rst), .tick(tick), .cec_line(cec_line),
        .cfg_wr(cfg_wr), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
        .start_det(start_det), .bit_vld(bit_vld), .bit_val(bit_val),
        .err_vld(err_vld), .err_kind(err_kind), .blk_vld(blk_vld),
        .blk_data(blk_data), .blk_eom(blk_eom), .blk_ack(blk_ack)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (start_det) nstart++;
            if (bit_vld) begin nbits++; last_bit = int'(bit_val); end
            if (err_vld) begin nerr++; last_kind = int'(err_kind); end
            if (blk_vld) begin
                nblk++; last_data = blk_data; last_eom = blk_eom; last_ack = blk_ack;
            end
        end
    end

    // low ticks, high ticks, expected bit (-1 none), expected error kind (-1 none)
    localparam int NVEC = 15;
    localparam int VEC [NVEC][4] = '{
        '{20, 60,  1, -1}, '{50, 30,  0, -1}, '{13, 60,  1, -1},
        '{26, 50,  1, -1}, '{12, 70, -1,  1}, '{27, 60, -1,  1},
        '{43, 30,  0, -1}, '{56, 20,  0, -1}, '{57, 30, -1,  1},
        '{20, 40,  1,  2}, '{20, 92,  1, -1}, '{20, 94,  1,  3},
        '{20, 47,  1, -1}, '{20, 46,  1,  2}, '{40, 40, -1,  1}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic align();
        do begin @(negedge clk); #1; end while (ph != 2'd1);
    endtask

    task automatic hold(input logic lvl, input int n);
        cec_line = lvl;
        repeat (4 * n) @(negedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        cec_line = 1'b1;
        repeat (6) @(negedge clk);
        rst = 1'b0;
        nstart = 0; nbits = 0; nerr = 0; nblk = 0; last_bit = -1; last_kind = -1;
        align();
    endtask

    task automatic send_start();
        hold(1'b0, 121);
        hold(1'b1, 27);
    endtask

    task automatic send_bit(input logic b);
        if (b) begin hold(1'b0, 20); hold(1'b1, 60); end
        else   begin hold(1'b0, 50); hold(1'b1, 30); end
    endtask

    task automatic send_block(input logic [7:0] d, input logic eom, input logic ack);
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        send_bit(eom);
        send_bit(ack);
    endtask

    task automatic write_thr(input int idx, input int val);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_idx = 4'(idx); cfg_data = 10'(val);
        @(negedge clk);
        cfg_wr = 1'b0;
        align();
    endtask

    initial begin
        // R1 reset state
        repeat (4) @(negedge clk);
        chk(!start_det && !bit_vld && !err_vld && !blk_vld, "R1 strobes in reset",
            int'({start_det, bit_vld, err_vld, blk_vld}), 0);
        do_reset();
        @(negedge clk);
        chk(!start_det && !bit_vld && !err_vld && !blk_vld, "R1 strobes after reset",
            int'({start_det, bit_vld, err_vld, blk_vld}), 0);

        // R2 R5 R6 R7 R8: table of single data bits after a good start
        for (int v = 0; v < NVEC; v++) begin
            do_reset();
            hold(1'b1, 5);
            send_start();
            hold(1'b0, VEC[v][0]);
            hold(1'b1, VEC[v][1]);
            hold(1'b0, 1);
            chk(nstart == 1, $sformatf("R3 vec%0d start", v), nstart, 1);
            if (VEC[v][2] >= 0)
                chk(nbits == 1 && last_bit == VEC[v][2], $sformatf("R5 vec%0d bit", v),
                    last_bit, VEC[v][2]);
            else
                chk(nbits == 0, $sformatf("R6 vec%0d no bit", v), nbits, 0);
            if (VEC[v][3] >= 0)
                chk(nerr == 1 && last_kind == VEC[v][3], $sformatf("R7 R8 vec%0d err kind", v),
                    last_kind, VEC[v][3]);
            else
                chk(nerr == 0, $sformatf("R2 vec%0d no err", v), nerr, 0);
        end

        // R6 low that never ends
        do_reset(); hold(1'b1, 5); send_start();
        hold(1'b0, 115); hold(1'b1, 30); hold(1'b0, 1);
        chk(nerr == 1 && last_kind == 1, "R6 long low", last_kind, 1);
        chk(nbits == 0, "R6 long low no bit", nbits, 0);

        // R3 start boundaries
        do_reset(); hold(1'b1, 5); hold(1'b0, 115); hold(1'b1, 27); hold(1'b0, 1);
        chk(nstart == 1 && nerr == 0, "R3 start low 115", nstart, 1);
        do_reset(); hold(1'b1, 5); hold(1'b0, 128); hold(1'b1, 20); hold(1'b0, 1);
        chk(nstart == 1 && nerr == 0, "R3 start low 128 high 20", nstart, 1);

        // R4 start violations
        do_reset(); hold(1'b1, 5); hold(1'b0, 114); hold(1'b1, 27); hold(1'b0, 1);
        chk(nstart == 0 && nerr == 1 && last_kind == 0, "R4 start low 114", last_kind, 0);
        do_reset(); hold(1'b1, 5); hold(1'b0, 135); hold(1'b1, 30); hold(1'b0, 1);
        chk(nstart == 0 && nerr == 1 && last_kind == 0, "R4 start low too long", nerr, 1);
        do_reset(); hold(1'b1, 5); hold(1'b0, 128); hold(1'b1, 27); hold(1'b0, 1);
        chk(nstart == 0 && nerr == 1 && last_kind == 0, "R4 start total 155", nerr, 1);
        do_reset(); hold(1'b1, 5); hold(1'b0, 121); hold(1'b1, 40); hold(1'b0, 1);
        chk(nstart == 0 && nerr == 1 && last_kind == 0, "R4 start high 40", nerr, 1);

        // R12 fall that revealed the error begins a new start bit
        do_reset(); hold(1'b1, 5); hold(1'b0, 121); hold(1'b1, 19);
        hold(1'b0, 121); hold(1'b1, 27); hold(1'b0, 1);
        chk(nerr == 1 && last_kind == 0, "R12 first start rejected", nerr, 1);
        chk(nstart == 1, "R12 second start accepted", nstart, 1);

        // R9 R10 frame with end of message
        do_reset(); hold(1'b1, 5); send_start();
        send_block(8'hA5, 1'b1, 1'b0);
        hold(1'b1, 150);
        chk(nbits == 10, "R9 ten bits", nbits, 10);
        chk(nblk == 1 && last_data == 8'hA5, "R9 block data", int'(last_data), 8'hA5);
        chk(last_eom == 1'b1 && last_ack == 1'b0, "R9 eom ack",
            int'({last_eom, last_ack}), 2);
        chk(nerr == 0, "R10 idle after eom quiet", nerr, 0);

        // R9 two blocks
        do_reset(); hold(1'b1, 5); send_start();
        send_block(8'h3C, 1'b0, 1'b0);
        send_block(8'h96, 1'b1, 1'b1);
        hold(1'b1, 150);
        chk(nblk == 2 && last_data == 8'h96, "R9 second block", int'(last_data), 8'h96);
        chk(last_eom && last_ack && nerr == 0, "R9 second eom ack",
            int'({last_eom, last_ack}), 3);

        // R8 frame cut short after a block without end of message
        do_reset(); hold(1'b1, 5); send_start();
        send_block(8'h5A, 1'b0, 1'b1);
        hold(1'b1, 150);
        chk(nblk == 1 && last_data == 8'h5A, "R8 block before cut", int'(last_data), 8'h5A);
        chk(nerr == 1 && last_kind == 3, "R8 long high mid frame", last_kind, 3);

        // R10 fall straight after eom block is a start bit
        do_reset(); hold(1'b1, 5); send_start();
        send_block(8'h81, 1'b1, 1'b0);
        send_start();
        hold(1'b0, 1);
        chk(nstart == 2 && nerr == 0, "R10 start after eom", nstart, 2);

        // R11 reprogrammed one-window upper bound
        do_reset();
        write_thr(7, 30);
        hold(1'b1, 5); send_start();
        hold(1'b0, 28); hold(1'b1, 60); hold(1'b0, 1);
        chk(nbits == 1 && last_bit == 1 && nerr == 0, "R11 low 28 accepted as 1", last_bit, 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog R2 actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule